// File: doc/BRIEF.md
# Writeback Invalidation Snoop Controller with Exclusive and Owned States

This block is the coherence controller for one private, direct-mapped, writeback data cache that sits on a shared snooping bus. It serves load and store requests from its processor. It issues bus reads, read-for-ownership requests and victim writebacks as a bus master. It also watches the transactions of other caches on a snoop port. A wired-OR shared line is sampled when a fill completes. If the line is high, the new line is held as a shared copy. If it is low, the line is held as the only clean copy, and a later store to that line needs no bus traffic.

Each line is in one of five states: invalid, shared, exclusive, owned or modified. The owned state exists only when the `MOESI` parameter is non-zero. In that case a dirty line that another cache reads stays dirty in this cache, and this cache supplies the data for every later read of it. With `MOESI` at zero, the same event demotes the line to shared. The controller drives its own shared output whenever a snooped bus read hits a valid line. It places line data on the flush port when it must act as the data source. For a clean shared copy, it does so only while the supplier-select input names this cache.

Bus arbitration and main memory are outside the block. A bus transaction is requested by holding `bm_req` and ends on a one-cycle `bm_done`. Snoops are never presented in the same cycle as `bm_done` for this cache's own transaction.

Top module: `msc_coherence_ctrl`

## Requirements
- R1: A load that misses issues a bus read (`bm_cmd` code 0) for the requested address and returns the fetched word. The filled line becomes exclusive if `shared_in` was low in the `bm_done` cycle, and shared if it was high.
- R2: A store to an exclusive or modified line completes with no bus transaction and leaves the line modified.
- R3: A store to an invalid, shared or owned line issues a read-for-ownership (`bm_cmd` code 1) and leaves the line modified, holding the store data.
- R4: A load that hits a valid line completes with no bus transaction and returns the newest data of that line. `pr_ready` is a single-cycle pulse.
- R5: `shared_out` is high in the cycle after a snooped bus read (`sn_cmd` code 0) whose address matches a valid line. It is low after a snooped read-for-ownership (`sn_cmd` code 1) and after any snoop that does not match.
- R6: On an exclusive line, a snooped bus read flushes the data and moves the line to shared. A snooped read-for-ownership invalidates the line without a flush.
- R7: On a shared line, a snooped bus read keeps the line shared and a snooped read-for-ownership invalidates it. In both cases the line is flushed only if `sup_sel` was high with the snoop.
- R8: On a modified line, a snooped bus read flushes the data. The line then becomes owned when `MOESI` is non-zero and shared otherwise. A snooped read-for-ownership flushes the data and invalidates the line.
- R9: On an owned line, every snooped bus read flushes the data and leaves the line owned. A snooped read-for-ownership flushes the data and invalidates the line.
- R10: A miss that replaces a modified or owned line first writes the victim back (`bm_cmd` code 2, with the victim's address and data). Only then does it request the new line. Replacing an exclusive or shared line is silent.
- R11: A snoop whose address matches no valid line changes no line, and raises neither `shared_out` nor `flush_valid`.
- R12: After reset every line is invalid, and `pr_ready`, `bm_req`, `shared_out` and `flush_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pr_valid | input | 1 | Processor request, held until `pr_ready` |
| pr_write | input | 1 | 1 = store, 0 = load |
| pr_addr | input | ADDR_W | Word address of the request |
| pr_wdata | input | DATA_W | Store data |
| pr_ready | output | 1 | One-cycle completion pulse |
| pr_rdata | output | DATA_W | Load result (store data for stores) |
| bm_req | output | 1 | Bus transaction requested, held until `bm_done` |
| bm_cmd | output | 2 | 0 bus read, 1 read-for-ownership, 2 writeback |
| bm_addr | output | ADDR_W | Transaction address |
| bm_wdata | output | DATA_W | Writeback data |
| bm_done | input | 1 | One-cycle transaction completion |
| bm_rdata | input | DATA_W | Fill data, valid with `bm_done` |
| shared_in | input | 1 | Wired shared line, sampled with `bm_done` |
| sn_valid | input | 1 | Snooped transaction present |
| sn_cmd | input | 2 | 0 bus read, 1 read-for-ownership |
| sn_addr | input | ADDR_W | Snooped address |
| sup_sel | input | 1 | This cache is the chosen supplier for a shared copy |
| shared_out | output | 1 | This cache holds the snooped line (bus reads only) |
| flush_valid | output | 1 | Flush data is being driven |
| flush_data | output | DATA_W | Line data supplied cache-to-cache |

## Verification
Every starting state (shared, exclusive, modified, owned) is swept against both snoop kinds and both supplier-select values. Each case checks the flush and shared responses, and then probes the resulting state with a load and then a store. The probe's bus activity separates invalid, clean-sole, shared-or-owned and modified outcomes. Directed sequences cover the victim path: a dirty or owned victim must produce a writeback carrying its address and data ahead of the fill, and a clean victim must produce the fill alone. Snoops to a different tag in the same set and to an empty cache check that non-matching traffic leaves the line untouched.

// File: rtl/msc_pkg.sv
package msc_pkg;

  typedef enum logic [2:0] {
    LS_I = 3'd0,
    LS_S = 3'd1,
    LS_E = 3'd2,
    LS_O = 3'd3,
    LS_M = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    BC_RD  = 2'd0,
    BC_RDX = 2'd1,
    BC_WB  = 2'd2
  } bus_cmd_e;

  typedef enum logic [1:0] {
    P_IDLE = 2'd0,
    P_WB   = 2'd1,
    P_FILL = 2'd2
  } pstate_e;

endpackage

// File: rtl/msc_line_store.sv
module msc_line_store import msc_pkg::*; #(
  parameter int INDEX_W = 2,
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INDEX_W-1:0] ra_idx,
  output line_st_e           ra_st,
  output logic [TAG_W-1:0]   ra_tag,
  output logic [DATA_W-1:0]  ra_data,
  input  logic [INDEX_W-1:0] rb_idx,
  output line_st_e           rb_st,
  output logic [TAG_W-1:0]   rb_tag,
  output logic [DATA_W-1:0]  rb_data,
  input  logic               wa_en,
  input  logic [INDEX_W-1:0] wa_idx,
  input  line_st_e           wa_st,
  input  logic [TAG_W-1:0]   wa_tag,
  input  logic [DATA_W-1:0]  wa_data,
  input  logic               sb_en,
  input  logic [INDEX_W-1:0] sb_idx,
  input  line_st_e           sb_st
);
  localparam int SETS = 1 << INDEX_W;

  logic [2:0]        st_q   [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  // Tag and data carry no reset so they map onto plain RAM.
  always_ff @(posedge clk) begin
    if (wa_en) begin
      tag_q[wa_idx]  <= wa_tag;
      data_q[wa_idx] <= wa_data;
    end
  end

  // State bits: snoop update first, processor update wins on the same set.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SETS; i++) st_q[i] <= LS_I;
    end else begin
      if (sb_en) st_q[sb_idx] <= sb_st;
      if (wa_en) st_q[wa_idx] <= wa_st;
    end
  end

  assign ra_st   = line_st_e'(st_q[ra_idx]);
  assign ra_tag  = tag_q[ra_idx];
  assign ra_data = data_q[ra_idx];
  assign rb_st   = line_st_e'(st_q[rb_idx]);
  assign rb_tag  = tag_q[rb_idx];
  assign rb_data = data_q[rb_idx];

endmodule

// File: rtl/msc_proc_rules.sv
module msc_proc_rules import msc_pkg::*; (
  input  line_st_e cur,
  input  logic     hit,
  input  logic     is_wr,
  output logic     done_now,
  output logic     need_wb,
  output bus_cmd_e fill_cmd,
  output line_st_e hit_nxt
);
  always_comb begin
    done_now = 1'b0;
    need_wb  = 1'b0;
    fill_cmd = is_wr ? BC_RDX : BC_RD;
    hit_nxt  = cur;
    if (hit) begin
      if (!is_wr) begin
        done_now = 1'b1;
      end else if (cur == LS_E || cur == LS_M) begin
        done_now = 1'b1;
        hit_nxt  = LS_M;
      end else begin
        fill_cmd = BC_RDX;
      end
    end else begin
      need_wb = (cur == LS_M) || (cur == LS_O);
    end
  end
endmodule

// File: rtl/msc_snoop_rules.sv
module msc_snoop_rules import msc_pkg::*; #(
  parameter int MOESI = 1
) (
  input  line_st_e cur,
  input  logic     hit,
  input  logic     is_rd,
  input  logic     is_rdx,
  input  logic     sup_sel,
  output line_st_e nxt,
  output logic     upd,
  output logic     flush,
  output logic     shared
);
  line_st_e dirty_rd_nxt;

  generate
    if (MOESI != 0) begin : g_owned
      assign dirty_rd_nxt = LS_O;
    end else begin : g_no_owned
      assign dirty_rd_nxt = LS_S;
    end
  endgenerate

  always_comb begin
    nxt    = cur;
    upd    = 1'b0;
    flush  = 1'b0;
    shared = hit && is_rd;
    if (hit && (is_rd || is_rdx)) begin
      upd = 1'b1;
      unique case (cur)
        LS_S: begin
          flush = sup_sel;
          nxt   = is_rdx ? LS_I : LS_S;
        end
        LS_E: begin
          flush = is_rd;
          nxt   = is_rdx ? LS_I : LS_S;
        end
        LS_M: begin
          flush = 1'b1;
          nxt   = is_rdx ? LS_I : dirty_rd_nxt;
        end
        LS_O: begin
          flush = 1'b1;
          nxt   = is_rdx ? LS_I : LS_O;
        end
        default: upd = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/msc_coherence_ctrl.sv
module msc_coherence_ctrl import msc_pkg::*; #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int INDEX_W = 2,
  parameter int MOESI   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pr_valid,
  input  logic              pr_write,
  input  logic [ADDR_W-1:0] pr_addr,
  input  logic [DATA_W-1:0] pr_wdata,
  output logic              pr_ready,
  output logic [DATA_W-1:0] pr_rdata,
  output logic              bm_req,
  output logic [1:0]        bm_cmd,
  output logic [ADDR_W-1:0] bm_addr,
  output logic [DATA_W-1:0] bm_wdata,
  input  logic              bm_done,
  input  logic [DATA_W-1:0] bm_rdata,
  input  logic              shared_in,
  input  logic              sn_valid,
  input  logic [1:0]        sn_cmd,
  input  logic [ADDR_W-1:0] sn_addr,
  input  logic              sup_sel,
  output logic              shared_out,
  output logic              flush_valid,
  output logic [DATA_W-1:0] flush_data
);
  localparam int TAG_W = ADDR_W - INDEX_W;

  // Address split
  logic [INDEX_W-1:0] pa_idx, sa_idx;
  logic [TAG_W-1:0]   pa_tag, sa_tag;
  assign pa_idx = pr_addr[INDEX_W-1:0];
  assign pa_tag = pr_addr[ADDR_W-1:INDEX_W];
  assign sa_idx = sn_addr[INDEX_W-1:0];
  assign sa_tag = sn_addr[ADDR_W-1:INDEX_W];

  // Line store
  line_st_e           ra_st, rb_st;
  logic [TAG_W-1:0]   ra_tag, rb_tag;
  logic [DATA_W-1:0]  ra_data, rb_data;
  logic               wa_en, sb_en;
  logic [INDEX_W-1:0] wa_idx;
  line_st_e           wa_st, sb_st;
  logic [TAG_W-1:0]   wa_tag;
  logic [DATA_W-1:0]  wa_data;

  msc_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .ra_idx(pa_idx), .ra_st(ra_st), .ra_tag(ra_tag), .ra_data(ra_data),
    .rb_idx(sa_idx), .rb_st(rb_st), .rb_tag(rb_tag), .rb_data(rb_data),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_st(wa_st), .wa_tag(wa_tag), .wa_data(wa_data),
    .sb_en(sb_en), .sb_idx(sa_idx), .sb_st(sb_st)
  );

  // Processor-side decisions
  logic     pr_hit, done_now, need_wb;
  bus_cmd_e fill_cmd;
  line_st_e hit_nxt;
  assign pr_hit = (ra_st != LS_I) && (ra_tag == pa_tag);

  msc_proc_rules u_prules (
    .cur(ra_st), .hit(pr_hit), .is_wr(pr_write),
    .done_now(done_now), .need_wb(need_wb), .fill_cmd(fill_cmd), .hit_nxt(hit_nxt)
  );

  // Snoop-side decisions
  logic sn_hit, sn_upd, sn_flush, sn_shared;
  assign sn_hit = (rb_st != LS_I) && (rb_tag == sa_tag);

  msc_snoop_rules #(.MOESI(MOESI)) u_srules (
    .cur(rb_st), .hit(sn_hit),
    .is_rd(sn_cmd == BC_RD), .is_rdx(sn_cmd == BC_RDX), .sup_sel(sup_sel),
    .nxt(sb_st), .upd(sn_upd), .flush(sn_flush), .shared(sn_shared)
  );
  assign sb_en = sn_valid && sn_upd;

  // Sequencer registers
  pstate_e            pst;
  logic [INDEX_W-1:0] cur_idx;
  logic [TAG_W-1:0]   cur_tag;
  logic [DATA_W-1:0]  cur_wdata;
  bus_cmd_e           fill_q;
  logic               pr_ready_q, bm_req_q, shared_q, flush_valid_q;
  logic [DATA_W-1:0]  pr_rdata_q, bm_wdata_q, flush_data_q;
  logic [1:0]         bm_cmd_q;
  logic [ADDR_W-1:0]  bm_addr_q;

  logic               accept, fill_end;
  line_st_e           fill_st;
  logic [DATA_W-1:0]  fill_data;

  assign accept    = (pst == P_IDLE) && pr_valid && !pr_ready_q && !sn_valid;
  assign fill_end  = (pst == P_FILL) && bm_done;
  assign fill_st   = (fill_q == BC_RD) ? (shared_in ? LS_S : LS_E) : LS_M;
  assign fill_data = (fill_q == BC_RD) ? bm_rdata : cur_wdata;

  // Processor write port into the line store
  always_comb begin
    wa_en   = 1'b0;
    wa_idx  = pa_idx;
    wa_st   = hit_nxt;
    wa_tag  = pa_tag;
    wa_data = pr_wdata;
    if (accept && done_now && pr_write) begin
      wa_en = 1'b1;
    end else if (fill_end) begin
      wa_en   = 1'b1;
      wa_idx  = cur_idx;
      wa_st   = fill_st;
      wa_tag  = cur_tag;
      wa_data = fill_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pst           <= P_IDLE;
      cur_idx       <= '0;
      cur_tag       <= '0;
      cur_wdata     <= '0;
      fill_q        <= BC_RD;
      pr_ready_q    <= 1'b0;
      pr_rdata_q    <= '0;
      bm_req_q      <= 1'b0;
      bm_cmd_q      <= BC_RD;
      bm_addr_q     <= '0;
      bm_wdata_q    <= '0;
      shared_q      <= 1'b0;
      flush_valid_q <= 1'b0;
      flush_data_q  <= '0;
    end else begin
      pr_ready_q    <= 1'b0;
      shared_q      <= sn_valid && sn_shared;
      flush_valid_q <= sn_valid && sn_flush;
      if (sn_valid && sn_flush) flush_data_q <= rb_data;

      unique case (pst)
        P_IDLE: begin
          if (accept) begin
            if (done_now) begin
              pr_ready_q <= 1'b1;
              pr_rdata_q <= pr_write ? pr_wdata : ra_data;
            end else begin
              cur_idx   <= pa_idx;
              cur_tag   <= pa_tag;
              cur_wdata <= pr_wdata;
              fill_q    <= fill_cmd;
              bm_req_q  <= 1'b1;
              if (need_wb) begin
                pst        <= P_WB;
                bm_cmd_q   <= BC_WB;
                bm_addr_q  <= {ra_tag, pa_idx};
                bm_wdata_q <= ra_data;
              end else begin
                pst       <= P_FILL;
                bm_cmd_q  <= fill_cmd;
                bm_addr_q <= pr_addr;
              end
            end
          end
        end
        P_WB: begin
          if (bm_done) begin
            pst       <= P_FILL;
            bm_cmd_q  <= fill_q;
            bm_addr_q <= {cur_tag, cur_idx};
          end
        end
        P_FILL: begin
          if (bm_done) begin
            pst        <= P_IDLE;
            bm_req_q   <= 1'b0;
            pr_ready_q <= 1'b1;
            pr_rdata_q <= fill_data;
          end
        end
        default: pst <= P_IDLE;
      endcase
    end
  end

  assign pr_ready    = pr_ready_q;
  assign pr_rdata    = pr_rdata_q;
  assign bm_req      = bm_req_q;
  assign bm_cmd      = bm_cmd_q;
  assign bm_addr     = bm_addr_q;
  assign bm_wdata    = bm_wdata_q;
  assign shared_out  = shared_q;
  assign flush_valid = flush_valid_q;
  assign flush_data  = flush_data_q;

endmodule

// File: rtl/msc_coherence_chk.sv
module msc_coherence_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pr_ready,
  input logic              bm_req,
  input logic [1:0]        bm_cmd,
  input logic [ADDR_W-1:0] bm_addr,
  input logic              bm_done,
  input logic              sn_valid,
  input logic [1:0]        sn_cmd,
  input logic              shared_out,
  input logic              flush_valid
);
  // R12
  p_reset_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pr_ready && !bm_req && !shared_out && !flush_valid));

  // R4
  p_ready_single_r4: assert property (@(posedge clk) disable iff (rst)
    pr_ready |=> !pr_ready);

  // R5
  p_shared_only_bus_rd_r5: assert property (@(posedge clk) disable iff (rst)
    shared_out |-> ($past(sn_valid) && $past(sn_cmd) == 2'd0));

  // R7
  p_flush_after_snoop_r7: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> $past(sn_valid));

  // R10
  p_bus_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (bm_req && !bm_done) |=> (bm_req && $stable(bm_cmd) && $stable(bm_addr)));

  // R10
  p_fill_after_wb_r10: assert property (@(posedge clk) disable iff (rst)
    (bm_req && bm_done && bm_cmd == 2'd2) |=> (bm_req && bm_cmd != 2'd2));

endmodule

bind msc_coherence_ctrl msc_coherence_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .pr_ready(pr_ready), .bm_req(bm_req), .bm_cmd(bm_cmd),
  .bm_addr(bm_addr), .bm_done(bm_done), .sn_valid(sn_valid), .sn_cmd(sn_cmd),
  .shared_out(shared_out), .flush_valid(flush_valid)
);

// File: tb/msc_coherence_ctrl_tb.sv
`timescale 1ns/1ps
module msc_coherence_ctrl_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam int MO = 1;
  localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_WB = 2'd2;
  // tb state codes
  localparam int T_S = 0, T_E = 1, T_M = 2, T_O = 3, T_I = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic pr_valid = 0, pr_write = 0, pr_ready;
  logic [AW-1:0] pr_addr = '0;
  logic [DW-1:0] pr_wdata = '0, pr_rdata;
  logic bm_req, bm_done = 0, shared_in = 0;
  logic [1:0] bm_cmd;
  logic [AW-1:0] bm_addr;
  logic [DW-1:0] bm_wdata, bm_rdata = '0;
  logic sn_valid = 0, sup_sel = 0, shared_out, flush_valid;
  logic [1:0] sn_cmd = '0;
  logic [AW-1:0] sn_addr = '0;
  logic [DW-1:0] flush_data;

  msc_coherence_ctrl #(.ADDR_W(AW), .DATA_W(DW), .INDEX_W(IW), .MOESI(MO)) u_dut (
    .clk(clk), .rst(rst), .pr_valid(pr_valid), .pr_write(pr_write), .pr_addr(pr_addr),
    .pr_wdata(pr_wdata), .pr_ready(pr_ready), .pr_rdata(pr_rdata),
    .bm_req(bm_req), .bm_cmd(bm_cmd), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
    .bm_done(bm_done), .bm_rdata(bm_rdata), .shared_in(shared_in),
    .sn_valid(sn_valid), .sn_cmd(sn_cmd), .sn_addr(sn_addr), .sup_sel(sup_sel),
    .shared_out(shared_out), .flush_valid(flush_valid), .flush_data(flush_data)
  );

  logic [DW-1:0] mem [256];
  int vecs = 0, bad = 0;
  int tx_cnt = 0, wait_cnt = 0;
  logic [1:0]    tx_cmd  [4];
  logic [AW-1:0] tx_addr [4];
  logic [DW-1:0] tx_data [4];
  logic sh_drive = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Bus and memory model
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h5000 + i[15:0];
    forever begin
      @(negedge clk);
      if (bm_done) begin
        bm_done = 0; shared_in = 0; wait_cnt = 0;
      end else if (bm_req) begin
        wait_cnt++;
        if (wait_cnt == 2) begin
          if (tx_cnt < 4) begin
            tx_cmd[tx_cnt] = bm_cmd; tx_addr[tx_cnt] = bm_addr; tx_data[tx_cnt] = bm_wdata;
          end
          tx_cnt++;
          if (bm_cmd == C_WB) mem[bm_addr] = bm_wdata;
          bm_rdata  = mem[bm_addr];
          shared_in = sh_drive;
          bm_done   = 1;
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1; pr_valid = 0; sn_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic pr_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit sh, output logic [DW-1:0] rd);
    @(negedge clk);
    sh_drive = sh; tx_cnt = 0;
    pr_valid = 1; pr_write = wr; pr_addr = a; pr_wdata = d;
    do @(negedge clk); while (!pr_ready);
    rd = pr_rdata;
    pr_valid = 0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input bit sup,
                       output bit sh, output bit fv, output logic [DW-1:0] fd);
    @(negedge clk);
    sn_valid = 1; sn_cmd = c; sn_addr = a; sup_sel = sup;
    @(negedge clk);
    sn_valid = 0; sup_sel = 0;
    sh = shared_out; fv = flush_valid; fd = flush_data;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  localparam logic [AW-1:0] A  = 8'h14;
  localparam logic [AW-1:0] B  = 8'h24;
  localparam logic [AW-1:0] NM = 8'h34;

  initial begin
    logic [DW-1:0] rd, d, fd, val;
    bit sh, fv;
    string rq;
    int nx, st2;

    // R12: reset state
    do_reset();
    @(negedge clk);
    chk("R12 pr_ready", pr_ready, 0);
    chk("R12 bm_req", bm_req, 0);
    chk("R12 shared_out", shared_out, 0);
    chk("R12 flush_valid", flush_valid, 0);
    snoop(C_RD, A, 1, sh, fv, fd);
    chk("R11 empty snoop shared", sh, 0);
    chk("R11 empty snoop flush", fv, 0);

    // R1, R2, R4: exclusive fill then silent upgrade
    pr_op(0, A, 0, 0, rd);
    chk("R1 miss tx count", tx_cnt, 1);
    chk("R1 miss cmd", tx_cmd[0], C_RD);
    chk("R1 miss addr", tx_addr[0], A);
    chk("R1 miss data", rd, mem[A]);
    pr_op(1, A, 16'h1234, 0, rd);
    chk("R2 write on E no bus", tx_cnt, 0);
    pr_op(0, A, 0, 0, rd);
    chk("R4 hit no bus", tx_cnt, 0);
    chk("R4 hit data", rd, 16'h1234);
    pr_op(1, A, 16'h4321, 0, rd);
    chk("R2 write on M no bus", tx_cnt, 0);

    // R11: same set, other tag
    snoop(C_RD, NM, 1, sh, fv, fd);
    chk("R11 miss snoop shared", sh, 0);
    chk("R11 miss snoop flush", fv, 0);
    snoop(C_RDX, NM, 1, sh, fv, fd);
    chk("R11 miss rdx flush", fv, 0);
    pr_op(0, A, 0, 0, rd);
    chk("R11 line kept no bus", tx_cnt, 0);
    chk("R11 line kept data", rd, 16'h4321);

    // R10: dirty victim writes back before fill
    pr_op(0, B, 0, 0, rd);
    chk("R10 dirty evict tx count", tx_cnt, 2);
    chk("R10 wb cmd", tx_cmd[0], C_WB);
    chk("R10 wb addr", tx_addr[0], A);
    chk("R10 wb data", tx_data[0], 16'h4321);
    chk("R10 fill cmd", tx_cmd[1], C_RD);
    chk("R10 fill addr", tx_addr[1], B);
    chk("R10 fill data", rd, mem[B]);
    pr_op(0, A, 0, 0, rd);
    chk("R10 clean evict tx count", tx_cnt, 1);
    chk("R10 clean evict cmd", tx_cmd[0], C_RD);
    chk("R10 refetch data", rd, 16'h4321);
    if (MO != 0) begin
      pr_op(1, A, 16'h7777, 0, rd);
      snoop(C_RD, A, 0, sh, fv, fd);
      pr_op(0, B, 0, 0, rd);
      chk("R10 owned evict tx count", tx_cnt, 2);
      chk("R10 owned wb cmd", tx_cmd[0], C_WB);
      chk("R10 owned wb data", tx_data[0], 16'h7777);
    end

    // Sweep: starting state x snoop kind x supplier select
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 2; c++) begin
        for (int u = 0; u < 2; u++) begin
          if (s == T_O && MO == 0) continue;
          do_reset();
          val = 16'hA000 + 16'(s * 16 + c * 4 + u);
          case (s)
            T_S: begin
              pr_op(0, A, 0, 1, rd); d = mem[A];
              chk("R1 shared fill data", rd, d);
            end
            T_E: begin
              pr_op(0, A, 0, 0, rd); d = mem[A];
              chk("R1 excl fill data", rd, d);
            end
            default: begin
              pr_op(1, A, val, 0, rd); d = val;
              chk("R3 write miss cmd", tx_cmd[0], C_RDX);
              if (s == T_O) snoop(C_RD, A, 0, sh, fv, fd);
            end
          endcase
          rq = (s == T_S) ? "R7" : (s == T_E) ? "R6" : (s == T_M) ? "R8" : "R9";
          snoop(c[1:0], A, u[0], sh, fv, fd);
          if (c == 1) nx = T_I;
          else if (s == T_M) nx = (MO != 0) ? T_O : T_S;
          else if (s == T_O) nx = T_O;
          else nx = T_S;
          chk($sformatf("R5 shared s%0d c%0d u%0d", s, c, u), sh, (c == 0));
          chk($sformatf("%s flush s%0d c%0d u%0d", rq, s, c, u), fv,
              (s == T_S) ? u : (s == T_E) ? (c == 0) : 1);
          if (fv) chk($sformatf("%s flush data s%0d c%0d", rq, s, c), fd, d);
          // probe with a load
          pr_op(0, A, 0, 0, rd);
          chk($sformatf("%s probe load bus s%0d c%0d u%0d", rq, s, c, u), tx_cnt, (nx == T_I));
          chk($sformatf("R4 probe data s%0d c%0d u%0d", s, c, u), rd, (nx == T_I) ? mem[A] : d);
          st2 = (nx == T_I) ? T_E : nx;
          // probe with a store
          pr_op(1, A, val ^ 16'h0F0F, 0, rd);
          chk($sformatf("%s probe store bus s%0d c%0d u%0d", rq, s, c, u), tx_cnt,
              (st2 == T_S || st2 == T_O));
          if (st2 == T_S || st2 == T_O)
            chk($sformatf("R3 upgrade cmd s%0d c%0d", s, c), tx_cmd[0], C_RDX);
          pr_op(0, A, 0, 0, rd);
          chk($sformatf("R3 store data s%0d c%0d u%0d", s, c, u), rd, val ^ 16'h0F0F);
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule